// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block sits next to a small 8-bit processor core and decides which interrupt, if any, the core services next. The sources are the reset input, a software-interrupt instruction, an external request pin, a timer, a serial communications interface (SCI) and a serial peripheral interface (SPI). Each peripheral presents several status flags with matching enable bits. The block combines each peripheral's flags into one request. It holds all requests until the core reports that the current instruction has finished. At that boundary it applies the global mask and picks one winner by fixed priority.

The winner is reported as a one-cycle take pulse with a source code and the address pair of its vector. When nothing qualifies, a one-cycle no-interrupt pulse is given instead. Taking an interrupt sets the global mask. Software sets or clears the mask through two strobes.

The controller has two states. BOOT is held during reset. The single transition BOOT to RUN fires on the first clock after reset is released and issues the reset vector. RUN then loops to itself and arbitrates at every instruction boundary.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While `rst_n` is low (asynchronous), `take_irq`=0, `no_irq`=0, `imask`=1. On the first clock edge after release, `take_irq` pulses with `winner`=1 (reset), `vec_hi`=16'h1FFE and `vec_lo`=16'h1FFF.
- R2: Arbitration happens only on a clock edge where `insn_done`=1, and its result appears in the following cycle. When `insn_done`=0, the following cycle has `take_irq`=0 and `no_irq`=0, and requests stay pending.
- R3: `swi_exec` at a boundary is taken whatever `imask` is, with `winner`=2 and vector 16'h1FFC/16'h1FFD. It outranks every hardware source.
- R4: A hardware source is taken only when `imask`=0. A peripheral requests when at least one of its flag bits is set together with the enable bit at the same index.
- R5: Among hardware sources, external (`winner`=3, 16'h1FFA) beats timer (4, 16'h1FF8), which beats SCI (5, 16'h1FF6), which beats SPI (6, 16'h1FF4). `vec_lo` is always `vec_hi`+1.
- R6: The cycle after any take has `imask`=1. Otherwise `mask_set` sets the mask and `mask_clr` clears it, with set winning over clear. A take wins over `mask_clr` on the same edge.
- R7: A rising edge on `irq_in` is latched as pending, including an edge at the boundary edge itself. The pending bit clears when the external vector is taken. A level held high raises no further request.
- R8: At a boundary where nothing qualifies, the next cycle has `no_irq`=1, `take_irq`=0 and `winner`=0.
- R9: `take_irq` and `no_irq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the reset interrupt source |
| insn_done | input | 1 | Core's current instruction completes on this edge |
| swi_exec | input | 1 | The completing instruction is a software interrupt |
| irq_in | input | 1 | External request pin, rising-edge sensitive |
| mask_set | input | 1 | Software strobe to set the global mask |
| mask_clr | input | 1 | Software strobe to clear the global mask |
| tmr_flag | input | TMR_N | Timer status flags |
| tmr_en | input | TMR_N | Timer enables, paired by index |
| sci_flag | input | SCI_N | SCI status flags |
| sci_en | input | SCI_N | SCI enables, paired by index |
| spi_flag | input | SPI_N | SPI status flags |
| spi_en | input | SPI_N | SPI enables, paired by index |
| take_irq | output | 1 | One-cycle pulse: a vector is taken |
| no_irq | output | 1 | One-cycle pulse: boundary with no qualifying source |
| winner | output | 3 | Source code of the taken vector, 0 when none |
| vec_hi | output | 16 | Address of the vector's high byte |
| vec_lo | output | 16 | Address of the vector's low byte |
| imask | output | 1 | Global interrupt mask |

## Verification
Two pairs of events can land on the same edge. The first is a fresh rising edge on `irq_in` at the boundary where a pending external request is consumed. The second is a take together with a software `mask_clr`. Directed sequences force both coincidences, and random stimulus raises the strobes and pin toggles often enough to hit them many more times. The bench's own model settles each case: a fresh edge is consumed together with the pending bit (R7), and the take leaves the mask set (R6).

// File: rtl/irq_vector_arbiter_pkg.sv
package irq_vector_arbiter_pkg;
    localparam logic [15:0] VEC_TOP  = 16'h1FFE;
    localparam logic [15:0] VEC_STEP = 16'd2;
    localparam int          SRC_W    = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_RST  = 3'd1,
        SRC_SWI  = 3'd2,
        SRC_EXT  = 3'd3,
        SRC_TMR  = 3'd4,
        SRC_SCI  = 3'd5,
        SRC_SPI  = 3'd6
    } src_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } fsm_e;

    // Vector slots descend from the top in priority order.
    function automatic logic [15:0] vec_of(input src_e s);
        logic [15:0] rank;
        rank = 16'(s) - 16'd1;
        return VEC_TOP - (VEC_STEP * rank);
    endfunction
endpackage

// File: rtl/irq_flag_gather.sv
module irq_flag_gather #(
    parameter int N = 3
) (
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    output logic         req
);
    logic [N-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pair
            assign hit[i] = flag[i] & en[i];
        end
    endgenerate

    assign req = |hit;
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic consume,
    output logic pending_now
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise        = pin & ~prev_q;
    assign pending_now = pend_q | rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin;
            pend_q <= consume ? 1'b0 : pending_now;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vector_arbiter_pkg::*;
(
    input  logic boundary,
    input  logic swi,
    input  logic mask,
    input  logic ext_req,
    input  logic tmr_req,
    input  logic sci_req,
    input  logic spi_req,
    output src_e pick
);
    always_comb begin
        pick = SRC_NONE;
        if (boundary) begin
            if (swi)              pick = SRC_SWI;
            else if (mask)        pick = SRC_NONE;
            else if (ext_req)     pick = SRC_EXT;
            else if (tmr_req)     pick = SRC_TMR;
            else if (sci_req)     pick = SRC_SCI;
            else if (spi_req)     pick = SRC_SPI;
        end
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irq_vector_arbiter_pkg::*;
#(
    parameter int TMR_N = 3,
    parameter int SCI_N = 5,
    parameter int SPI_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             swi_exec,
    input  logic             irq_in,
    input  logic             mask_set,
    input  logic             mask_clr,
    input  logic [TMR_N-1:0] tmr_flag,
    input  logic [TMR_N-1:0] tmr_en,
    input  logic [SCI_N-1:0] sci_flag,
    input  logic [SCI_N-1:0] sci_en,
    input  logic [SPI_N-1:0] spi_flag,
    input  logic [SPI_N-1:0] spi_en,
    output logic             take_irq,
    output logic             no_irq,
    output logic [2:0]       winner,
    output logic [15:0]      vec_hi,
    output logic [15:0]      vec_lo,
    output logic             imask
);
    fsm_e state_q, state_d;
    src_e pick;
    src_e win_q;
    logic ext_req, tmr_req, sci_req, spi_req;
    logic consume_ext;

    irq_flag_gather #(.N(TMR_N)) u_tmr (.flag(tmr_flag), .en(tmr_en), .req(tmr_req));
    irq_flag_gather #(.N(SCI_N)) u_sci (.flag(sci_flag), .en(sci_en), .req(sci_req));
    irq_flag_gather #(.N(SPI_N)) u_spi (.flag(spi_flag), .en(spi_en), .req(spi_req));

    assign consume_ext = (state_q == ST_RUN) && (pick == SRC_EXT);

    irq_edge_latch u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (irq_in),
        .consume    (consume_ext),
        .pending_now(ext_req)
    );

    irq_prio_pick u_pick (
        .boundary(insn_done),
        .swi     (swi_exec),
        .mask    (imask),
        .ext_req (ext_req),
        .tmr_req (tmr_req),
        .sci_req (sci_req),
        .spi_req (spi_req),
        .pick    (pick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_irq <= 1'b0;
            no_irq   <= 1'b0;
            win_q    <= SRC_NONE;
            vec_hi   <= VEC_TOP;
            imask    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    take_irq <= 1'b1;
                    no_irq   <= 1'b0;
                    win_q    <= SRC_RST;
                    vec_hi   <= vec_of(SRC_RST);
                    imask    <= 1'b1;
                end
                ST_RUN: begin
                    take_irq <= (pick != SRC_NONE);
                    no_irq   <= insn_done && (pick == SRC_NONE);
                    win_q    <= pick;
                    if (pick != SRC_NONE) vec_hi <= vec_of(pick);
                    if (pick != SRC_NONE)  imask <= 1'b1;
                    else if (mask_set)     imask <= 1'b1;
                    else if (mask_clr)     imask <= 1'b0;
                end
                default: begin
                    take_irq <= 1'b0;
                    no_irq   <= 1'b0;
                end
            endcase
        end
    end

    assign winner = win_q;
    assign vec_lo = vec_hi + 16'd1;
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done,
    input logic        take_irq,
    input logic        no_irq,
    input logic [2:0]  winner,
    input logic [15:0] vec_hi,
    input logic        imask
);
    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_irq && no_irq));

    assert_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && winner != 3'd1) |-> $past(insn_done));

    assert_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_irq |-> ($past(insn_done) && winner == 3'd0));

    assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && winner >= 3'd3) |-> !$past(imask));

    assert_take_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> imask);

    assert_ext_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && winner == 3'd3) |-> vec_hi == 16'h1FFA);

    assert_swi_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && winner == 3'd2) |-> vec_hi == 16'h1FFC);
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .insn_done(insn_done),
    .take_irq (take_irq),
    .no_irq   (no_irq),
    .winner   (winner),
    .vec_hi   (vec_hi),
    .imask    (imask)
);

// File: tb/sim_irq_vector_arbiter.sv
`timescale 1ns/1ps
module sim_irq_vector_arbiter;
    localparam int TMR_N = 3;
    localparam int SCI_N = 5;
    localparam int SPI_N = 2;

    logic clk = 1'b0;
    logic rst_n, insn_done, swi_exec, irq_in, mask_set, mask_clr;
    logic [TMR_N-1:0] tmr_flag, tmr_en;
    logic [SCI_N-1:0] sci_flag, sci_en;
    logic [SPI_N-1:0] spi_flag, spi_en;
    logic take_irq, no_irq, imask;
    logic [2:0] winner;
    logic [15:0] vec_hi, vec_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit m_boot, m_mask, m_pend, m_prev;

    always #2.5 clk = ~clk;

    irq_vector_arbiter #(.TMR_N(TMR_N), .SCI_N(SCI_N), .SPI_N(SPI_N)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_src(input bit edge_now);
        if (m_boot) return 1;
        if (!insn_done) return 0;
        if (swi_exec) return 2;
        if (m_mask) return 0;
        if (m_pend || edge_now) return 3;
        if (|(tmr_flag & tmr_en)) return 4;
        if (|(sci_flag & sci_en)) return 5;
        if (|(spi_flag & spi_en)) return 6;
        return 0;
    endfunction

    function automatic logic [15:0] exp_vec(input int s);
        case (s)
            1: return 16'h1FFE;
            2: return 16'h1FFC;
            3: return 16'h1FFA;
            4: return 16'h1FF8;
            5: return 16'h1FF6;
            default: return 16'h1FF4;
        endcase
    endfunction

    task automatic model_reset();
        m_boot = 1; m_mask = 1; m_pend = 0; m_prev = 1;
    endtask

    // Inputs are already driven (at a negedge); one clock, compare, update model.
    task automatic step(input string tag);
        bit e;
        int s;
        bit exp_none;
        e = irq_in & ~m_prev;
        s = exp_src(e);
        exp_none = !m_boot && insn_done && (s == 0);
        @(posedge clk); #1;
        chk(take_irq == (s != 0), {tag, " take"}, take_irq, s != 0);
        chk(no_irq == exp_none, {tag, " R8 none"}, no_irq, exp_none);
        chk(int'(winner) == s, {tag, " winner"}, winner, s);
        if (s != 0) begin
            chk(vec_hi == exp_vec(s), {tag, " R5 vec_hi"}, vec_hi, exp_vec(s));
            chk(vec_lo == exp_vec(s) + 16'd1, {tag, " R5 vec_lo"}, vec_lo, exp_vec(s) + 16'd1);
        end
        if (s != 0)          m_mask = 1;
        else if (m_boot)     m_mask = 1;
        else if (mask_set)   m_mask = 1;
        else if (mask_clr)   m_mask = 0;
        chk(imask == m_mask, {tag, " R6 mask"}, imask, m_mask);
        if (s == 3) m_pend = 0; else m_pend = m_pend | e;
        m_prev = irq_in;
        m_boot = 0;
        @(negedge clk);
    endtask

    task automatic quiet();
        insn_done = 0; swi_exec = 0; mask_set = 0; mask_clr = 0;
        tmr_flag = '0; sci_flag = '0; spi_flag = '0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        #1;
        chk(take_irq == 0 && no_irq == 0, "R1 reset outputs", {take_irq, no_irq}, 0);
        chk(imask == 1, "R1 reset mask", imask, 1);
        model_reset();
        @(negedge clk);
        rst_n = 1;
        step("R1 boot");
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        quiet();
        irq_in = 0;
        tmr_en = '1; sci_en = '1; spi_en = '1;
        @(negedge clk);
        do_reset();

        // R2: mask clear, requests pending, no boundary
        mask_clr = 1; step("R6 clr");
        mask_clr = 0; tmr_flag = 3'b010; step("R2 mid-insn");
        step("R2 mid-insn2");
        insn_done = 1; step("R4 tmr taken");
        // R3: mask set, swi still taken
        quiet(); insn_done = 1; swi_exec = 1; sci_flag = 5'b00001; step("R3 swi masked");
        // R4: enable off blocks flag
        quiet(); mask_clr = 1; step("R6 clr2");
        quiet(); tmr_en = 3'b000; tmr_flag = 3'b111; insn_done = 1; step("R4 disabled");
        tmr_en = 3'b100; tmr_flag = 3'b100; mask_clr = 1; step("R6 take beats clr");
        // R5 and R7: ext + timer, ext wins; short pulse mid instruction
        quiet(); mask_clr = 1; irq_in = 1; step("R7 pulse hi");
        quiet(); irq_in = 0; step("R7 pulse lo");
        insn_done = 1; tmr_flag = 3'b001; tmr_en = 3'b111; step("R5 ext over tmr");
        quiet(); mask_clr = 1; step("R6 clr3");
        quiet(); tmr_flag = 3'b001; insn_done = 1; step("R5 tmr after ext");
        // R7: level held high is one request; edge on boundary consumed together
        quiet(); mask_clr = 1; step("R6 clr4");
        quiet(); irq_in = 1; insn_done = 1; step("R7 edge at boundary");
        quiet(); mask_clr = 1; step("R6 clr5");
        quiet(); insn_done = 1; step("R7 level no rerequest");
        // R5: sci over spi, then spi alone
        quiet(); mask_clr = 1; irq_in = 0; step("R6 clr6");
        quiet(); sci_flag = 5'b10000; spi_flag = 2'b11; insn_done = 1; step("R5 sci over spi");
        quiet(); mask_clr = 1; step("R6 clr7");
        quiet(); spi_flag = 2'b10; insn_done = 1; step("R5 spi");
        // R8: nothing qualifies
        quiet(); mask_clr = 1; step("R6 clr8");
        quiet(); insn_done = 1; step("R8 empty boundary");
        // R6: set wins over clear
        quiet(); mask_set = 1; mask_clr = 1; step("R6 set over clr");

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            insn_done = ($urandom % 3) == 0;
            swi_exec  = ($urandom % 16) == 0;
            mask_clr  = ($urandom % 3) == 0;
            mask_set  = ($urandom % 20) == 0;
            if (($urandom % 4) == 0) irq_in = ~irq_in;
            tmr_flag = ($urandom % 5 == 0) ? TMR_N'($urandom) : '0;
            sci_flag = ($urandom % 5 == 0) ? SCI_N'($urandom) : '0;
            spi_flag = ($urandom % 5 == 0) ? SPI_N'($urandom) : '0;
            tmr_en = TMR_N'($urandom); sci_en = SCI_N'($urandom); spi_en = SPI_N'($urandom);
            step("R9 random");
            if (k == 2000) begin
                quiet();
                do_reset();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule